// File: doc/BRIEF.md
# Three-wire serial EEPROM slave controller

This block is a synchronous model of the slave side of a three-wire serial nonvolatile memory. A host raises chip select, then clocks a command frame into the data-in pin on rising serial-clock edges. The frame is a start bit, a two-bit opcode, an address and, for writes, a data word. The block reads words out, changes its write-enable latch, and starts programming of one word or of the whole array. All pins are sampled with the system clock. A serial-clock rising edge is detected from two registered copies of the pin.

Programming is self-timed. It starts when chip select falls after a complete programming frame and runs for `PROG_CYCLES` system clocks. While it runs, raising chip select shows a low busy level on data-out. After it finishes, data-out shows a high ready level. That level stays latched until a start bit is clocked in or chip select falls again. The organization input selects 256 sixteen-bit words or 512 eight-bit bytes over the same storage. An undriven pin should be pulled high at the pad, which gives the sixteen-bit default.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, `dout_oe` is 0 and the write-enable latch is cleared.
- R2: While chip select is low, `dout_oe` is 0.
- R3: After chip select rises, 0 bits sampled before the first 1 are ignored, and that first 1 is the start bit.
- R4: A frame is sent in this order, each field most significant bit first: start bit, two opcode bits, address, then data if the command has any. Opcode 10 is read, 01 is write and 11 is erase. For opcode 00, the top two address bits select the command: 11 enables erase/write, 00 disables it, 01 is write-all (with data) and 10 is erase-all.
- R5: For a read, at the serial-clock edge that samples the last address bit, `dout_oe` goes to 1 with `dout` = 0 (a dummy bit). Each following rising edge presents the next data bit, most significant bit first.
- R6: With `org` = 1 there are 8 address bits and 16 data bits. With `org` = 0 there are 9 address bits and 8 data bits. Byte address a maps to bits [15:8] of word a[8:1] when a[0] = 1, and to bits [7:0] of that word when a[0] = 0.
- R7: Erase/write is disabled after reset and after the disable command. While it is disabled, write, erase, write-all and erase-all start no programming: no busy status appears, and memory contents are unchanged.
- R8: Programming starts only when chip select falls after a complete frame. A frame cut short by chip select falling changes nothing.
- R9: While programming, raising chip select drives `dout` low with `dout_oe` = 1. Programming lasts `PROG_CYCLES` clocks, and toggling chip select during it has no effect on it.
- R10: After programming ends, `dout` = 1 with `dout_oe` = 1 whenever chip select is high. This holds until a start bit is sampled or chip select falls, after which `dout_oe` returns to 0.
- R11: Erase sets every bit of the addressed word to 1. Erase-all sets the whole array to 1. Write-all stores the data word in every location.
- R12: A rise of chip select discards any partly received command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data is sampled on its rising edge |
| di | input | 1 | Serial data in |
| org | input | 1 | Word size select: 1 = 16-bit words, 0 = 8-bit words |
| dout | output | 1 | Serial data out or ready/busy level |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
The assertions check, on every cycle, the following: the output is released whenever chip select is low, the busy level is driven whenever the cycle runs with chip select high, and the ready level is driven once it is over. They also check that a started cycle enters and stays in busy until its terminal count. The frame decoding itself can only be shown by the bench's scenarios. This covers leading zeros, dummy-bit placement, byte-lane mapping between the two organizations, ignored commands while disabled, truncated frames, and the clearing of the ready level by a start bit or by a chip-select fall.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  localparam int unsigned WORD_AW = 8;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BYTE_AW = WORD_AW + 1;
  localparam int unsigned BYTE_W  = WORD_W / 2;
  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam int unsigned DEPTH   = 1 << WORD_AW;
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE} ser_st_t;
  typedef enum logic [2:0] {PG_NONE, PG_WRITE, PG_ERASE, PG_FILL, PG_CLEAR} pg_op_t;

  function automatic logic [CNT_W-1:0] addr_len(input logic wide);
    return wide ? CNT_W'(WORD_AW) : CNT_W'(BYTE_AW);
  endfunction

  function automatic logic [CNT_W-1:0] data_len(input logic wide);
    return wide ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
  endfunction

  function automatic logic [WORD_AW-1:0] word_index(input logic [BYTE_AW-1:0] a, input logic wide);
    return wide ? a[WORD_AW-1:0] : a[BYTE_AW-1:1];
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [BYTE_AW-1:0] a, input logic wide);
    return wide ? {LANES{1'b1}} : (LANES'(1) << a[0]);
  endfunction

  function automatic logic [WORD_W-1:0] spread(input logic [WORD_W-1:0] d, input logic wide);
    return wide ? d : {LANES{d[BYTE_W-1:0]}};
  endfunction

  function automatic logic [1:0] sys_cmd(input logic [BYTE_AW-1:0] a, input logic wide);
    return wide ? a[WORD_AW-1 -: 2] : a[BYTE_AW-1 -: 2];
  endfunction

  function automatic logic [WORD_W:0] read_frame(input logic [WORD_W-1:0] w,
                                                  input logic [BYTE_AW-1:0] a, input logic wide);
    if (wide) return {1'b0, w};
    return {1'b0, (a[0] ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0]), {BYTE_W{1'b0}}};
  endfunction
endpackage

// File: rtl/mw_pin_sampler.sv
module mw_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic s_cs,
  output logic s_di,
  output logic s_org,
  output logic sk_rise,
  output logic cs_fall
);
  logic cs_q, cs_qq, sk_q, sk_qq, di_q, org_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      cs_qq <= 1'b0;
      sk_q  <= 1'b0;
      sk_qq <= 1'b0;
      di_q  <= 1'b0;
      org_q <= 1'b1;
    end else begin
      cs_q  <= cs;
      cs_qq <= cs_q;
      sk_q  <= sk;
      sk_qq <= sk_q;
      di_q  <= di;
      org_q <= org;
    end
  end

  assign s_cs    = cs_q;
  assign s_di    = di_q;
  assign s_org   = org_q;
  assign sk_rise = sk_q & ~sk_qq;
  assign cs_fall = ~cs_q & cs_qq;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int unsigned CYCLES = 3750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned TW = $clog2(CYCLES + 1);
  logic [TW-1:0] cnt;

  assign done = busy && (cnt == TW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = WORD_W / LANE_W,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wall,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LANES-1:0]  wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && (wall || widx == IDX_W'(i))) begin
        for (int l = 0; l < LANES; l++) begin
          if (wmask[l]) mem[i][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 3750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic dout,
  output logic dout_oe
);
  logic s_cs, s_di, s_org, sk_rise, cs_fall;
  logic prog_busy, prog_done, prog_start;
  logic status_show, wr_enable;
  ser_st_t st;
  pg_op_t pend;
  logic [CNT_W-1:0] cnt;
  logic [1:0] opc;
  logic [BYTE_AW-1:0] addr, a_next;
  logic [WORD_W-1:0] data, rdata, wdata;
  logic [WORD_W:0] rsh;
  logic start_bit, addr_last, data_last, fill_all, ones;

  mw_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .s_cs(s_cs), .s_di(s_di), .s_org(s_org), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(prog_busy), .done(prog_done)
  );

  assign a_next    = {addr[BYTE_AW-2:0], s_di};
  assign addr_last = (cnt == addr_len(s_org) - 1'b1);
  assign data_last = (cnt == data_len(s_org) - 1'b1);
  assign start_bit = sk_rise && s_cs && !prog_busy && (st == ST_IDLE) && s_di;
  assign prog_start = cs_fall && (st == ST_DONE) && (pend != PG_NONE) && wr_enable;
  assign fill_all  = (pend == PG_FILL) || (pend == PG_CLEAR);
  assign ones      = (pend == PG_ERASE) || (pend == PG_CLEAR);
  assign wdata     = ones ? {WORD_W{1'b1}} : spread(data, s_org);

  mw_word_array #(.WORD_W(WORD_W), .IDX_W(WORD_AW), .LANE_W(BYTE_W)) u_array (
    .clk(clk),
    .we(prog_start),
    .wall(fill_all),
    .widx(word_index(addr, s_org)),
    .wmask(fill_all ? {LANES{1'b1}} : lane_mask(addr, s_org)),
    .wdata(wdata),
    .ridx(word_index(a_next, s_org)),
    .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pend        <= PG_NONE;
      cnt         <= '0;
      opc         <= '0;
      addr        <= '0;
      data        <= '0;
      rsh         <= '0;
      wr_enable   <= 1'b0;
      status_show <= 1'b0;
    end else begin
      if (!prog_busy && (cs_fall || start_bit)) status_show <= 1'b0;
      if (prog_start) status_show <= 1'b1;

      if (!s_cs) begin
        st   <= ST_IDLE;
        pend <= PG_NONE;
        cnt  <= '0;
      end else if (sk_rise && !prog_busy) begin
        unique case (st)
          ST_IDLE: if (s_di) begin
            st  <= ST_OPC;
            cnt <= '0;
          end
          ST_OPC: begin
            opc <= {opc[0], s_di};
            if (cnt == CNT_W'(1)) begin
              st  <= ST_ADDR;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_ADDR: begin
            addr <= a_next;
            cnt  <= cnt + 1'b1;
            if (addr_last) begin
              cnt <= '0;
              unique case (opc)
                2'b10: begin rsh <= read_frame(rdata, a_next, s_org); st <= ST_READ; end
                2'b01: begin pend <= PG_WRITE; st <= ST_DATA; end
                2'b11: begin pend <= PG_ERASE; st <= ST_DONE; end
                default: begin
                  unique case (sys_cmd(a_next, s_org))
                    2'b11:   begin wr_enable <= 1'b1; st <= ST_DONE; end
                    2'b00:   begin wr_enable <= 1'b0; st <= ST_DONE; end
                    2'b01:   begin pend <= PG_FILL;   st <= ST_DATA; end
                    default: begin pend <= PG_CLEAR;  st <= ST_DONE; end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            data <= {data[WORD_W-2:0], s_di};
            if (data_last) st <= ST_DONE;
            else           cnt <= cnt + 1'b1;
          end
          ST_READ: rsh <= {rsh[WORD_W-1:0], 1'b0};
          default: ;
        endcase
      end
    end
  end

  assign dout_oe = s_cs && (status_show || st == ST_READ);
  assign dout    = status_show ? ~prog_busy : rsh[WORD_W];
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_oe,
  input logic s_cs,
  input logic prog_busy,
  input logic prog_start,
  input logic prog_done,
  input logic status_show
);
  p_hiz_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout_oe);

  p_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs && prog_busy |-> dout_oe && !dout);

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy && !prog_done |=> prog_busy);

  p_busy_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !prog_busy);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> prog_busy && status_show);

  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs && status_show && !prog_busy |-> dout_oe && dout);
endmodule

bind mw_eeprom_ctrl mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_oe(dout_oe),
  .s_cs(s_cs), .prog_busy(prog_busy), .prog_start(prog_start),
  .prog_done(prog_done), .status_show(status_show)
);

// File: tb/mw_eeprom_ctrl_tb.sv
module mw_eeprom_ctrl_tb;
  localparam int PROG = 300;
  logic clk = 1'b0;
  logic rst_n, cs, sk, di, org;
  logic dout, dout_oe;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;
  logic obs_do, obs_oe;

  always #2 clk = ~clk;

  mw_eeprom_ctrl #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .dout(dout), .dout_oe(dout_oe)
  );

  // {address, data} written then read back in 16-bit mode
  localparam logic [23:0] VEC [6] = '{24'h10_C3A5, 24'h00_0001, 24'hFF_8000,
                                      24'h80_FFFE, 24'h01_1234, 24'h33_0F0F};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    di = b; tick(3);
    sk = 1'b1; tick(3);
    obs_do = dout; obs_oe = dout_oe;
    sk = 1'b0; di = 1'b0; tick(1);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_up();   cs = 1'b1; tick(3); endtask
  task automatic cs_down(); cs = 1'b0; tick(3); endtask

  function automatic int alen(); return org ? 8 : 9; endfunction
  function automatic int dlen(); return org ? 16 : 8; endfunction

  task automatic cmd(input logic [1:0] op, input logic [8:0] a, input int zeros);
    cs_up();
    for (int i = 0; i < zeros; i++) bit_out(1'b0);
    bit_out(1'b1);
    send(32'(op), 2);
    send(32'(a), alen());
  endtask

  task automatic do_write(input logic [8:0] a, input logic [15:0] d);
    cmd(2'b01, a, 0);
    send(32'(d), dlen());
    cs_down();
  endtask

  task automatic wait_ready(input string req, output int cycles);
    cs_up();
    check({req, " busy level"}, {30'd0, dout_oe, dout}, 32'h2);
    cycles = 0;
    while (!(dout_oe && dout) && cycles < 5000) begin tick(1); cycles++; end
    cs_down();
  endtask

  task automatic do_read(input logic [8:0] a, input int zeros, output logic [15:0] w);
    cmd(2'b10, a, zeros);
    check("R5 dummy bit", {30'd0, obs_oe, obs_do}, 32'h2);
    w = '0;
    for (int i = 0; i < dlen(); i++) begin
      bit_out(1'b0);
      w = {w[14:0], obs_do};
    end
    cs_down();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int cyc;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b1;
    tick(5);
    check("R1 reset oe", 32'(dout_oe), 32'h0);
    rst_n = 1'b1; tick(3);

    // R7: disabled after reset
    do_write(9'h10, 16'h1234);
    cs_up(); check("R7 no busy while disabled", 32'(dout_oe), 32'h0); cs_down();

    cmd(2'b00, 9'h0C0, 0); cs_down();   // enable
    for (int k = 0; k < 6; k++) begin
      do_write(9'(VEC[k][23:16]), VEC[k][15:0]);
      wait_ready("R9", cyc);
      if (k == 0) check("R9 duration", 32'((cyc + 6 >= PROG - 8) && (cyc + 6 <= PROG + 8)), 32'h1);
      do_read(9'(VEC[k][23:16]), 0, w);
      check("R4 R5 readback", 32'(w), 32'(VEC[k][15:0]));
    end

    // R2: deselected output released
    check("R2 hiz", 32'(dout_oe), 32'h0);

    // R9: toggling chip select during the cycle
    do_write(9'h44, 16'hBEEF);
    for (int t = 0; t < 3; t++) begin
      cs_up(); check("R9 toggle busy", {30'd0, dout_oe, dout}, 32'h2); cs_down(); tick(10);
    end
    wait_ready("R9", cyc);
    do_read(9'h44, 0, w);
    check("R9 data after toggling", 32'(w), 32'hBEEF);

    // R10: ready latched, cleared by start bit
    do_write(9'h45, 16'h0102);
    cs_up(); tick(PROG + 20);
    check("R10 ready", {30'd0, dout_oe, dout}, 32'h3);
    bit_out(1'b0);
    check("R10 zero keeps ready", {30'd0, obs_oe, obs_do}, 32'h3);
    bit_out(1'b1);
    check("R10 start bit clears", 32'(obs_oe), 32'h0);
    cs_down();
    cs_up(); check("R10 cs fall clears", 32'(dout_oe), 32'h0); cs_down();

    // R3: leading zeros
    do_read(9'h45, 3, w);
    check("R3 leading zeros", 32'(w), 32'h0102);

    // R12: partial command discarded
    cs_up(); bit_out(1'b1); send(32'b01, 2); send(32'h4, 4); cs_down();
    cs_up(); check("R12 no busy after cut", 32'(dout_oe), 32'h0); cs_down();
    do_read(9'h45, 0, w);
    check("R12 intact", 32'(w), 32'h0102);

    // R8: missing last data bit
    cmd(2'b01, 9'h45, 0); send(32'h7FFF, 15); cs_down();
    cs_up(); check("R8 truncated no busy", 32'(dout_oe), 32'h0); cs_down();
    do_read(9'h45, 0, w);
    check("R8 unchanged", 32'(w), 32'h0102);

    // R11: erase one word
    cmd(2'b11, 9'h01, 0); cs_down(); wait_ready("R11", cyc);
    do_read(9'h01, 0, w);
    check("R11 erase", 32'(w), 32'hFFFF);

    // R6: byte organization
    org = 1'b0; tick(3);
    do_write(9'h021, 16'h00A5); wait_ready("R6", cyc);
    do_read(9'h021, 0, w);
    check("R6 byte upper", 32'(w), 32'hA5);
    do_read(9'h020, 0, w);
    check("R6 byte lower", 32'(w), 32'hA5);
    org = 1'b1; tick(3);
    do_read(9'h10, 0, w);
    check("R6 lane map", 32'(w), 32'hA5A5);

    // R11: write-all and erase-all
    cmd(2'b00, 9'h040, 0); send(32'h5A3C, 16); cs_down(); wait_ready("R11", cyc);
    do_read(9'h00, 0, w); check("R11 fill low", 32'(w), 32'h5A3C);
    do_read(9'hFF, 0, w); check("R11 fill high", 32'(w), 32'h5A3C);
    cmd(2'b00, 9'h080, 0); cs_down(); wait_ready("R11", cyc);
    do_read(9'h33, 0, w); check("R11 clear all", 32'(w), 32'hFFFF);

    // R7: disable blocks write
    cmd(2'b00, 9'h000, 0); cs_down();
    do_write(9'h33, 16'h0000);
    cs_up(); check("R7 disabled no busy", 32'(dout_oe), 32'h0); cs_down();
    do_read(9'h33, 0, w); check("R7 unchanged", 32'(w), 32'hFFFF);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule